// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block is the address side of a bus unit. It holds four 16-bit segment bases (extra, code, stack and data) and a 16-bit instruction pointer. From a segment:offset pair it forms a 20-bit physical address: the segment value is shifted left by four bits and the 16-bit offset is added. Segments therefore begin on 16-byte boundaries, and each segment reaches 64 KB from its base. A sum that goes past FFFFFh wraps around the 1 MB space.

There are two kinds of request. A fetch request combines the code segment with the instruction pointer, and the pointer then advances by one byte. An operand request combines a selected segment with an offset that the caller supplies, such as a base or index value. The result appears one cycle after the request, registered, together with a single-cycle valid pulse. A write port loads any of the segment registers or the instruction pointer.

Top module: `seg_addr_gen`

## Requirements
- R1: After reset, all segment registers and the instruction pointer are zero, `addr_valid` is 0 and `phys_addr` is 00000h.
- R2: A fetch request in cycle n gives `phys_addr` = code segment × 16 + instruction pointer in cycle n+1, with `addr_valid` high for that one cycle. For example, code segment 2500h with pointer 95F3h gives 2E5F3h.
- R3: Each fetch request increments the instruction pointer by one, modulo 2^16 (FFFFh is followed by 0000h). The code segment does not change.
- R4: An operand request gives `phys_addr` = selected segment × 16 + `op_off` one cycle later, with a valid pulse. The `op_seg` codes are 0 = extra, 1 = code, 2 = stack and 3 = data.
- R5: The 20-bit sum drops any carry out of bit 19, so the address wraps modulo 2^20. For example, FFFFh:0010h gives 00000h.
- R6: When a fetch request and an operand request arrive in the same cycle, the fetch is served and the operand request is dropped.
- R7: The `wr_sel` codes 0 to 3 load the segment with the same code as `op_seg`, and code 4 loads the instruction pointer. Codes 5, 6 and 7 change nothing.
- R8: A write takes effect from the next cycle. A request in the same cycle as the write uses the old value. A pointer write in the same cycle as a fetch replaces the increment.
- R9: In a cycle after a cycle with no request, `addr_valid` is 0 and `phys_addr` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Write target: 0..3 segment, 4 instruction pointer |
| wr_data | input | 16 | Write value |
| fetch_req | input | 1 | Instruction-byte address request |
| op_req | input | 1 | Operand address request |
| op_seg | input | 2 | Operand segment: 0 extra, 1 code, 2 stack, 3 data |
| op_off | input | 16 | Operand offset |
| phys_addr | output | 20 | Registered physical address |
| addr_valid | output | 1 | One-cycle strobe marking a new address |

## Verification
Fetch runs from a mid-range pointer show whether the shift and add are correct and whether the pointer advances. A run that starts at pointer FFFFh separates a 16-bit pointer wrap from a carry into the segment. Operand requests use a different value in each segment register and the same offset, so a wrong select decode shows up as a wrong address. A segment of FFFFh with small and large offsets exercises the 20-bit wrap. Requests that coincide with each other or with writes show the fetch priority and the rule that a write takes effect one cycle later.

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
  parameter int SEG_W  = 16,
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [SEG_W-1:0]  wr_data,
  input  logic              fetch_req,
  input  logic              op_req,
  input  logic [1:0]        op_seg,
  input  logic [SEG_W-1:0]  op_off,
  output logic [ADDR_W-1:0] phys_addr,
  output logic              addr_valid
);
  localparam int SHIFT   = ADDR_W - SEG_W;
  localparam int NSEG    = 4;
  localparam int CODE_IX = 1;
  localparam logic [2:0] IP_SEL = 3'd4;

  logic [SEG_W-1:0] seg_q [NSEG];
  logic [SEG_W-1:0] ip_q;
  logic [SEG_W-1:0] cs_cur;
  logic [SEG_W-1:0] base_seg;
  logic [SEG_W-1:0] offset;
  logic [ADDR_W-1:0] sum;
  logic             req;

  assign cs_cur   = seg_q[CODE_IX];
  assign req      = fetch_req | op_req;
  assign base_seg = fetch_req ? cs_cur : seg_q[op_seg];
  assign offset   = fetch_req ? ip_q : op_off;
  assign sum      = {base_seg, {SHIFT{1'b0}}} + ADDR_W'(offset);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSEG; i++) seg_q[i] <= '0;
    end else if (wr_en && wr_sel < IP_SEL) begin
      seg_q[wr_sel[1:0]] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        ip_q <= '0;
    else if (wr_en && wr_sel == IP_SEL) ip_q <= wr_data;
    else if (fetch_req)                 ip_q <= ip_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phys_addr  <= '0;
      addr_valid <= 1'b0;
    end else begin
      addr_valid <= req;
      if (req) phys_addr <= sum;
    end
  end
endmodule

module seg_addr_gen_chk #(
  parameter int SEG_W  = 16,
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [2:0]        wr_sel,
  input logic              fetch_req,
  input logic              op_req,
  input logic [ADDR_W-1:0] phys_addr,
  input logic              addr_valid,
  input logic [SEG_W-1:0]  cs_q,
  input logic [SEG_W-1:0]  ip_q
);
  // R2
  req_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req || op_req) |=> addr_valid);
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fetch_req || op_req) |=> (!addr_valid && $stable(phys_addr)));
  // R2
  fetch_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |=> phys_addr[3:0] == $past(ip_q[3:0]));
  // R3
  ip_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && !(wr_en && wr_sel == 3'd4)) |=> ip_q == SEG_W'($past(ip_q) + 1'b1));
  // R3
  cs_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && !(wr_en && wr_sel == 3'd1)) |=> $stable(cs_q));
  // R7
  bad_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel > 3'd4 && !fetch_req) |=> ($stable(ip_q) && $stable(cs_q)));
endmodule

bind seg_addr_gen seg_addr_gen_chk #(.SEG_W(SEG_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
  .fetch_req(fetch_req), .op_req(op_req), .phys_addr(phys_addr),
  .addr_valid(addr_valid), .cs_q(cs_cur), .ip_q(ip_q)
);

// File: tb/seg_addr_gen_tb.sv
module seg_addr_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic        fetch_req = 1'b0;
  logic        op_req = 1'b0;
  logic [1:0]  op_seg = '0;
  logic [15:0] op_off = '0;
  logic [19:0] phys_addr;
  logic        addr_valid;

  always #2 clk = ~clk;

  seg_addr_gen u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .fetch_req(fetch_req), .op_req(op_req), .op_seg(op_seg), .op_off(op_off),
    .phys_addr(phys_addr), .addr_valid(addr_valid)
  );

  typedef struct {
    logic        v;
    logic [19:0] a;
    string       r;
  } exp_t;

  exp_t        sb[$];
  int          checks = 0;
  int          errors = 0;
  logic [15:0] m_seg [4];
  logic [15:0] m_ip;
  logic [19:0] m_last;
  logic        done = 1'b0;

  task automatic check(input bit ok, input string r, input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%05h expected=%05h", r, act, exp);
    end
  endtask

  task automatic step(input bit f, input bit o, input logic [1:0] s, input logic [15:0] off,
                      input bit w, input logic [2:0] ws, input logic [15:0] wd, input string r);
    exp_t e;
    @(negedge clk);
    fetch_req = f; op_req = o; op_seg = s; op_off = off;
    wr_en = w; wr_sel = ws; wr_data = wd;
    e.r = r;
    if (f) begin
      e.v = 1'b1; e.a = {m_seg[1], 4'h0} + {4'h0, m_ip};
    end else if (o) begin
      e.v = 1'b1; e.a = {m_seg[s], 4'h0} + {4'h0, off};
    end else begin
      e.v = 1'b0; e.a = m_last;
    end
    m_last = e.a;
    sb.push_back(e);
    if (f) m_ip = m_ip + 16'd1;
    if (w) begin
      if (ws < 3'd4) m_seg[ws[1:0]] = wd;
      else if (ws == 3'd4) m_ip = wd;
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check(addr_valid == e.v, {e.r, " valid"}, {19'd0, addr_valid}, {19'd0, e.v});
      check(phys_addr == e.a, {e.r, " addr"}, phys_addr, e.a);
    end
  end

  task automatic wr(input logic [2:0] ws, input logic [15:0] wd, input string r);
    step(1'b0, 1'b0, 2'd0, 16'h0, 1'b1, ws, wd, r);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) m_seg[i] = '0;
    m_ip = '0; m_last = '0;
    repeat (3) @(negedge clk);
    check(addr_valid == 1'b0 && phys_addr == 20'h0, "R1 reset", phys_addr, 20'h0);
    rst_n = 1'b1;
    // R1: first fetch from zeroed registers
    step(1, 0, 0, 0, 0, 0, 0, "R1 fetch");
    // R2, R3
    wr(3'd1, 16'h2500, "R7 cs");
    wr(3'd4, 16'h95F3, "R7 ip");
    step(1, 0, 0, 0, 0, 0, 0, "R2 2E5F3");
    step(1, 0, 0, 0, 0, 0, 0, "R3 step");
    step(1, 0, 0, 0, 0, 0, 0, "R3 step2");
    wr(3'd4, 16'hFFFF, "R7 ip");
    step(1, 0, 0, 0, 0, 0, 0, "R3 top");
    step(1, 0, 0, 0, 0, 0, 0, "R3 wrap");
    // R4
    wr(3'd0, 16'h1000, "R7 es");
    wr(3'd2, 16'h3000, "R7 ss");
    wr(3'd3, 16'h4000, "R7 ds");
    step(0, 1, 2'd0, 16'h0123, 0, 0, 0, "R4 es");
    step(0, 1, 2'd1, 16'h0123, 0, 0, 0, "R4 cs");
    step(0, 1, 2'd2, 16'h0123, 0, 0, 0, "R4 ss");
    step(0, 1, 2'd3, 16'h0123, 0, 0, 0, "R4 ds");
    // R9
    step(0, 0, 0, 0, 0, 0, 0, "R9 idle");
    step(0, 0, 0, 0, 0, 0, 0, "R9 idle2");
    // R5
    wr(3'd3, 16'hFFFF, "R7 ds");
    step(0, 1, 2'd3, 16'h0010, 0, 0, 0, "R5 wrap0");
    step(0, 1, 2'd3, 16'hFFFF, 0, 0, 0, "R5 wrapmax");
    step(0, 1, 2'd3, 16'h000F, 0, 0, 0, "R5 top");
    // R6
    step(1, 1, 2'd0, 16'hAAAA, 0, 0, 0, "R6 both");
    step(1, 0, 0, 0, 0, 0, 0, "R6 ip advanced");
    // R7: codes 5..7 ignored
    wr(3'd5, 16'h1234, "R7 sel5");
    wr(3'd6, 16'h5678, "R7 sel6");
    wr(3'd7, 16'h9ABC, "R7 sel7");
    step(1, 0, 0, 0, 0, 0, 0, "R7 ip kept");
    step(0, 1, 2'd0, 16'h0, 0, 0, 0, "R7 es kept");
    step(0, 1, 2'd2, 16'h0, 0, 0, 0, "R7 ss kept");
    step(0, 1, 2'd3, 16'h0, 0, 0, 0, "R7 ds kept");
    // R8
    step(0, 1, 2'd3, 16'h0005, 1, 3'd3, 16'h0800, "R8 old ds");
    step(0, 1, 2'd3, 16'h0005, 0, 0, 0, "R8 new ds");
    step(1, 0, 0, 0, 1, 3'd4, 16'h4444, "R8 old ip");
    step(1, 0, 0, 0, 0, 0, 0, "R8 ip write wins");
    step(1, 0, 0, 0, 1, 3'd1, 16'h0001, "R8 old cs");
    step(1, 0, 0, 0, 0, 0, 0, "R8 new cs");
    step(0, 0, 0, 0, 0, 0, 0, "R9 hold");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule